// File: doc/BRIEF.md
# Serial Signed-Digit to BCD Digit Finisher

This block sits behind an accumulator of signed decimal digits that shifts right by one position per step. The digit that drops out at the low end is never touched again, so it can be finished at once. The block turns it into a plain BCD digit, one digit per clock and least significant product digit first. Each incoming digit lies in -6..+6 and is coded as a 4-bit two's complement value.

A negative or zero digit cannot always be shown as a BCD digit on its own. In that case the block borrows one unit from the next higher position. It keeps that pending -1 in a single stored bit and applies it to the next digit it converts. When the lowest digits are done, the stored bit is presented to the following stage, which finishes the upper digits and takes the borrow in.

A clear pulse starts a new product. When it arrives together with a valid digit, that digit is the first of the new product and is converted as if no borrow were pending.

Top module: `sdbcd_lsd_conv`

## Requirements
- R1: When a valid digit is 1 or more and no borrow is pending, the next cycle's BCD output equals that digit and the borrow becomes 0.
- R2: When a valid digit is 1 or more and a borrow is pending, the output is the digit minus one and the borrow becomes 0. A 1 therefore yields 0.
- R3: When a valid digit d is 0 or less and the pending borrow is b, the output is 10 + d - b, reduced to its low four bits. The one exception is d = 0 with b = 0, which yields 0.
- R4: The new borrow is 1 when the valid digit is negative, or when it is zero and a borrow was pending. In every other case it is 0.
- R5: A clear pulse without a valid digit resets the borrow to 0. A clear pulse with a valid digit converts that digit with the borrow taken as 0.
- R6: In a cycle without a valid digit, the borrow and the BCD output keep their values, whatever the digit input carries.
- R7: The output valid flag is the input valid flag delayed by one clock. The output digit and the borrow change in the same cycle as the output valid flag.
- R8: While the synchronous active-low reset is held at a clock edge, the output valid flag, the BCD output and the borrow are all 0.
- R9: Every output digit is a BCD value from 0 to 9.
- R10: For any stream of N valid digits started with a clear, the sum of the output digits weighted by powers of ten, minus the final borrow times 10^N, equals the value of the signed-digit input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Start of a new product; clears the pending borrow |
| in_vld | input | 1 | The input digit is valid this cycle |
| in_digit | input | DIGIT_W | Signed digit, two's complement, in -6..+6 |
| out_vld | output | 1 | The BCD output holds a new digit |
| out_bcd | output | 4 | Finished BCD product digit |
| borrow | output | 1 | Pending borrow for the next higher position |

## Verification
The bench builds the block with its default 4-bit digit width. At that width all thirteen legal digit values can be combined with both borrow states. The two borrow states are set up through a clear pulse that carries a digit of -1 or 0. Random signed-digit streams of 1 to 12 digits, some of them with idle gaps, then check the weighted-sum identity of R10 at product lengths where the final borrow carries real weight.

// File: rtl/sdbcd_pkg.sv
// Shared types and constants for the signed-digit to BCD digit finisher.
// Assumes decimal digits with a four-bit BCD output.
package sdbcd_pkg;
    localparam int unsigned BCD_W = 4;
    localparam int          RADIX = 10;
    localparam int          MAX_MAG = 6;
    typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/sdbcd_digit_conv.sv
// Combinational conversion of one signed digit and a pending borrow into a BCD
// digit and an outgoing borrow. The digit is treated as a weight-one value: it
// subtracts the borrow, and a negative difference is wrapped by adding the radix,
// which raises the outgoing borrow.
// Assumes the digit lies in -MAX_MAG..+MAX_MAG, so one wrap is always enough.
module sdbcd_digit_conv
    import sdbcd_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic [DIGIT_W-1:0] digit,
    input  logic               borrow_in,
    output bcd_t               bcd,
    output logic               borrow_out
);
    localparam int SUM_W = DIGIT_W + 2;

    logic signed [SUM_W-1:0] diff_s;
    logic signed [SUM_W-1:0] wrapped_s;

    // Subtract the pending borrow, then wrap a negative difference into 0..9.
    always_comb begin
        diff_s     = $signed({{2{digit[DIGIT_W-1]}}, digit})
                   - $signed({{(SUM_W-1){1'b0}}, borrow_in});
        wrapped_s  = diff_s + $signed(SUM_W'(RADIX));
        borrow_out = diff_s[SUM_W-1];
        bcd        = borrow_out ? wrapped_s[BCD_W-1:0] : diff_s[BCD_W-1:0];
    end
endmodule

// File: rtl/sdbcd_borrow_reg.sv
// One-bit store for the borrow that is pending between successive product digits.
// It loads a new value on valid cycles and is cleared by a start pulse. A start
// pulse on a valid cycle masks the old value, so that digit sees no borrow.
// Assumes a synchronous active-low reset.
module sdbcd_borrow_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic borrow_nxt,
    output logic borrow_q,
    output logic borrow_eff
);
    // Borrow the current digit should use: the stored bit, unless a new product starts now.
    always_comb borrow_eff = borrow_q & ~clr;

    // Hold, load or clear the stored borrow.
    always_ff @(posedge clk) begin
        if (!rst_n)    borrow_q <= 1'b0;
        else if (load) borrow_q <= borrow_nxt;
        else if (clr)  borrow_q <= 1'b0;
    end
endmodule

// File: rtl/sdbcd_out_stage.sv
// Output register for the finished digit and its valid flag. The digit is
// loaded only on valid cycles and holds otherwise.
// Assumes a synchronous active-low reset.
module sdbcd_out_stage
    import sdbcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vld_in,
    input  bcd_t bcd_in,
    output logic vld_out,
    output bcd_t bcd_out
);
    // Register the valid flag and capture the digit when it is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_out <= 1'b0;
            bcd_out <= '0;
        end else begin
            vld_out <= vld_in;
            if (vld_in) bcd_out <= bcd_in;
        end
    end
endmodule

// File: rtl/sdbcd_lsd_conv.sv
// Top level of the serial finisher. Each valid signed digit that leaves the
// accumulator is converted to BCD using the stored borrow. The result appears
// one clock later, and the borrow moves on to the next digit.
// Assumes legal digits in -6..+6 whenever in_vld is high.
module sdbcd_lsd_conv
    import sdbcd_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               in_vld,
    input  logic [DIGIT_W-1:0] in_digit,
    output logic               out_vld,
    output logic [BCD_W-1:0]   out_bcd,
    output logic               borrow
);
    logic borrow_eff;
    logic borrow_nxt;
    bcd_t conv_bcd;

    sdbcd_borrow_reg u_borrow (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .load       (in_vld),
        .borrow_nxt (borrow_nxt),
        .borrow_q   (borrow),
        .borrow_eff (borrow_eff)
    );

    sdbcd_digit_conv #(.DIGIT_W(DIGIT_W)) u_conv (
        .digit      (in_digit),
        .borrow_in  (borrow_eff),
        .bcd        (conv_bcd),
        .borrow_out (borrow_nxt)
    );

    sdbcd_out_stage u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_in  (in_vld),
        .bcd_in  (conv_bcd),
        .vld_out (out_vld),
        .bcd_out (out_bcd)
    );

    // Legal input range, assumed by the single-wrap conversion (R3).
    a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ($signed(in_digit) >= -MAX_MAG && $signed(in_digit) <= MAX_MAG));

    // Positive digit with no borrow passes straight through (R1).
    a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !clr && !borrow && $signed(in_digit) > 0)
        |=> (out_bcd == BCD_W'($past(in_digit)) && !borrow));

    // A 1 with a borrow pending gives 0 and settles the borrow (R2).
    a_r2_one_absorbs: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !clr && borrow && $signed(in_digit) == 1)
        |=> (out_bcd == '0 && !borrow));

    // A negative digit always leaves a borrow behind (R4).
    a_r4_neg_borrows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && $signed(in_digit) < 0) |=> borrow);

    // A clear pulse alone empties the borrow (R5).
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !in_vld) |=> !borrow);

    // Idle cycles keep the borrow and the digit (R6).
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld && !clr) |=> ($stable(borrow) && $stable(out_bcd)));

    // The valid flag is delayed by exactly one clock (R7).
    a_r7_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_vld == $past(in_vld)));

    // The output is always a decimal digit (R9).
    a_r9_bcd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_bcd <= BCD_W'(9)));
endmodule

// File: tb/sdbcd_lsd_conv_tb.sv
module sdbcd_lsd_conv_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       in_vld = 1'b0;
    logic [3:0] in_digit = '0;
    logic       out_vld;
    logic [3:0] out_bcd;
    logic       borrow;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdbcd_lsd_conv u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld),
        .in_digit(in_digit), .out_vld(out_vld), .out_bcd(out_bcd), .borrow(borrow)
    );

    task automatic chk(input longint act, input longint exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one digit at a falling edge; the outputs are settled at the next falling edge.
    task automatic feed(input int d, input bit c);
        in_vld   = 1'b1;
        in_digit = 4'(d);
        clr      = c;
        @(negedge clk);
        in_vld = 1'b0;
        clr    = 1'b0;
    endtask

    task automatic idle(input int cycles, input int junk);
        in_vld   = 1'b0;
        in_digit = 4'(junk);
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        int hold_bcd;
        @(negedge clk);
        in_vld = 1'b1; in_digit = 4'(-3);
        repeat (3) @(negedge clk);
        chk(out_vld, 0, "R8 out_vld in reset");
        chk(out_bcd, 0, "R8 out_bcd in reset");
        chk(borrow, 0, "R8 borrow in reset");
        in_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Every digit against both borrow states.
        for (int b = 0; b < 2; b++) begin
            for (int d = -6; d <= 6; d++) begin
                int t;
                feed(b ? -1 : 0, 1'b1);
                chk(borrow, b, "R5 borrow set-up via clear");
                feed(d, 1'b0);
                t = d - b;
                chk(out_bcd, (t < 0) ? t + 10 : t,
                    (d > 0) ? (b ? "R2 out_bcd" : "R1 out_bcd") : "R3 out_bcd");
                chk(borrow, (t < 0) ? 1 : 0, "R4 borrow");
                chk(out_vld, 1, "R7 out_vld after valid");
            end
        end

        // Clear with a valid digit ignores an old borrow.
        feed(-4, 1'b0);
        feed(5, 1'b1);
        chk(out_bcd, 5, "R5 clear with digit");
        chk(borrow, 0, "R5 clear with digit borrow");

        // Idle cycles keep the state.
        feed(-2, 1'b0);
        hold_bcd = out_bcd;
        idle(1, 5);
        chk(out_vld, 0, "R7 out_vld drops");
        idle(2, 5);
        chk(borrow, 1, "R6 borrow hold");
        chk(out_bcd, hold_bcd, "R6 out_bcd hold");
        in_digit = 4'(-6);
        clr = 1'b0;
        idle(2, -6);
        chk(borrow, 1, "R6 borrow hold negative junk");

        // Random streams check the weighted-sum identity.
        for (int s = 0; s < 400; s++) begin
            int     n;
            longint p, vin, vout;
            n = 1 + int'($urandom_range(11));
            p = 1; vin = 0; vout = 0;
            for (int k = 0; k < n; k++) begin
                int d;
                d = int'($urandom_range(12)) - 6;
                feed(d, k == 0);
                chk(out_bcd <= 9, 1, "R9 digit range");
                vin  += longint'(d) * p;
                vout += longint'(out_bcd) * p;
                p *= 10;
                if ($urandom_range(3) == 0) idle(1, int'($urandom_range(15)));
            end
            chk(vout - longint'(borrow) * p, vin, "R10 stream value");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule